// File: doc/BRIEF.md
# Time-Slotted Three-Stream Frame Buffer

This block collects three independent byte streams (upstream protocol frames, downstream protocol frames, and statistics or acknowledgement frames) into one pipelined, zero-wait, 36-bit single-port memory, and plays them back on a single, slower output port. Each symbol is stored as 9 bits: a data byte and a delimiter bit that marks the last symbol of a frame. Each writer packs four symbols into one 36-bit word.

A free-running four-cycle schedule shares the memory. Cycles 0, 1 and 2 belong to the three writers and cycle 3 to the reader, so every stream keeps line rate without arbitration. Each stream owns a circular region of the memory. The reader empties a whole frame from one region before it moves on. It serves regions holding complete frames in rotating order. A frame that would not fit is discarded at its first symbol and counted.

The senders must respect two limits. Frames carry at most MAX_FRAME symbols. Each frame is followed by at least three idle cycles on its stream.

Top module: `tsb_ctrl`

## Requirements
- R1: After a synchronous active-low reset, out_valid is low and every drop counter reads zero.
- R2: Every accepted frame leaves the output with its symbols unchanged and in arrival order per stream. out_last is high only on its final symbol. out_region carries the stream code: 0 upstream, 1 downstream, 2 statistics or acknowledgement.
- R3: The memory is accessed at most once per clock on a fixed four-cycle rotation. Stream s writes only in slot s (s = 0, 1, 2) and reads happen only in slot 3. All three streams can deliver frames at the same time without loss.
- R4: Four symbols share one 36-bit word. The first symbol sits in bits [8:0] and each following symbol in the next 9 bits. Bit 8 of a symbol is the delimiter. A frame whose length (1 to MAX_FRAME) is not a multiple of four ends in a padded word, and the padding never reaches the output.
- R5: Once a frame's first symbol is output, all of its symbols are output before any symbol of another frame.
- R6: When several regions hold complete frames, consecutive frames come from regions in rotating order 0, 1, 2, 0, and so on.
- R7: If a region's free words minus its not-yet-written words are fewer than ceil(MAX_FRAME/4) when a frame's first symbol arrives, the whole frame is discarded. That region's drop counter, at drop_cnt[s*CNT_W +: CNT_W], then rises by one.
- R8: A drop counter stops at its all-ones value.
- R9: While out_valid is high and out_ready is low, out_valid, out_data, out_last and out_region hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 3 | Per-stream symbol valid, bit s for stream s |
| in_data | input | 24 | Per-stream data byte, stream s at [8s+7:8s] |
| in_last | input | 3 | Per-stream last-symbol marker |
| out_ready | input | 1 | Output sink accepts a symbol |
| out_valid | output | 1 | Output symbol present |
| out_data | output | 8 | Output data byte |
| out_last | output | 1 | Output symbol ends its frame |
| out_region | output | 2 | Stream code of the output frame |
| drop_cnt | output | 3*CNT_W | Saturating per-region drop counters |

## Verification
The hardest states to reach are the ones where several regions are loaded at the same moment. Round-robin order only shows when all three regions hold complete frames together, and the drop rule only fires once a region is nearly full. The bench gets there by holding out_ready low while the streams load frames, then releasing it and watching the region sequence. For the drop case it overfills one region with a sequence of frames whose fate it predicts from a word-count model, then pushes hundreds of one-symbol frames against the full region until the counter saturates.

// File: rtl/tsb_pkg.sv
// Shared word layout for the time-slotted buffer: four 9-bit symbols per
// 36-bit word, symbol 0 in the low bits, bit 8 of each symbol a delimiter.
package tsb_pkg;
    localparam int SYM_W   = 9;
    localparam int LANES   = 4;
    localparam int WORD_W  = SYM_W * LANES;
    localparam int NSTREAM = 3;

    // Number of valid symbols in a word: up to and including the first delimiter.
    function automatic logic [2:0] valid_lanes(input logic [WORD_W-1:0] w);
        logic [2:0] n;
        logic       seen;
        n    = 3'd4;
        seen = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (!seen && w[i*SYM_W+8]) begin
                n    = 3'(i + 1);
                seen = 1'b1;
            end
        end
        return n;
    endfunction

    // True when the word closes a frame.
    function automatic logic ends_frame(input logic [WORD_W-1:0] w);
        logic e;
        e = 1'b0;
        for (int i = 0; i < LANES; i++) e = e | w[i*SYM_W+8];
        return e;
    endfunction
endpackage

// File: rtl/tsb_sram.sv
// Behavioural single-port pipelined memory. One access per clock, no wait
// states; read data appears two clocks after the address is presented.
// Assumes the caller never reads and writes in the same cycle.
module tsb_sram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] addr_q;

    // Write port and address register stage.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        addr_q <= addr;
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        rdata <= mem[addr_q];
    end
endmodule

// File: rtl/tsb_writer.sv
// One input stream: packs symbols into words, decides at each frame start
// whether the frame fits, queues finished words (two deep) until the
// stream's slot, and keeps the region's circular pointers and counts.
// Assumes frames of at most MAX_FRAME symbols and three idle cycles after
// each frame, which keeps the two-entry queue from overflowing.
module tsb_writer
    import tsb_pkg::*;
#(
    parameter int REGION_WORDS = 16,
    parameter int MAX_FRAME    = 16,
    parameter int CNT_W        = 8,
    parameter int MY_SLOT      = 0,
    localparam int PTR_W       = $clog2(REGION_WORDS),
    localparam int OCC_W       = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        slot,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic              rd_take,
    input  logic              frame_done,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [WORD_W-1:0] wr_word,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic              frame_avail,
    output logic [CNT_W-1:0]  drops
);
    localparam int MAX_WORDS = (MAX_FRAME + LANES - 1) / LANES;
    localparam logic [OCC_W+1:0] MAXW_V  = (OCC_W+2)'(MAX_WORDS);
    localparam logic [OCC_W+1:0] DEPTH_V = (OCC_W+2)'(REGION_WORDS);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [OCC_W-1:0]  occ, frm_cnt;
    logic [1:0]        q_cnt, pack_cnt;
    logic [WORD_W-1:0] pack_data, next_word, q0, q1;
    logic              in_frame, dropping;
    logic              space_ok, sym_ok, word_done, push, pop;

    // Room check for a new frame: stored words plus queued words plus one maximum frame.
    assign space_ok  = ({2'b00, occ} + {{OCC_W{1'b0}}, q_cnt} + MAXW_V) <= DEPTH_V;
    assign sym_ok    = in_valid && (in_frame ? !dropping : space_ok);
    assign word_done = (pack_cnt == 2'd3) || in_last;
    assign push      = sym_ok && word_done;
    assign pop       = (slot == 2'(MY_SLOT)) && (q_cnt != 2'd0);

    assign wr_en       = pop;
    assign wr_word     = q0;
    assign frame_avail = (frm_cnt != '0);

    // Insert the incoming symbol into its lane of the word under assembly.
    always_comb begin
        next_word = pack_data;
        next_word[int'(pack_cnt)*SYM_W +: SYM_W] = {in_last, in_data};
    end

    // Packer: collect symbols, restart after each finished word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pack_data <= '0;
            pack_cnt  <= 2'd0;
        end else if (sym_ok) begin
            if (word_done) begin
                pack_data <= '0;
                pack_cnt  <= 2'd0;
            end else begin
                pack_data <= next_word;
                pack_cnt  <= pack_cnt + 2'd1;
            end
        end
    end

    // Frame tracking and admission: accept or discard whole frames at the first symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            dropping <= 1'b0;
            drops    <= '0;
        end else if (in_valid) begin
            if (!in_frame) begin
                if (!space_ok && drops != CNT_TOP) drops <= drops + 1'b1;
                if (!in_last) begin
                    in_frame <= 1'b1;
                    dropping <= !space_ok;
                end
            end else if (in_last) begin
                in_frame <= 1'b0;
                dropping <= 1'b0;
            end
        end
    end

    // Two-entry word queue between the packer and the write slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q0    <= '0;
            q1    <= '0;
            q_cnt <= 2'd0;
        end else begin
            case ({push, pop})
                2'b10: begin
                    if (q_cnt == 2'd0) q0 <= next_word;
                    else               q1 <= next_word;
                    q_cnt <= q_cnt + 2'd1;
                end
                2'b01: begin
                    q0    <= q1;
                    q_cnt <= q_cnt - 2'd1;
                end
                2'b11: begin
                    if (q_cnt == 2'd1) q0 <= next_word;
                    else begin
                        q0 <= q1;
                        q1 <= next_word;
                    end
                end
                default: ;
            endcase
        end
    end

    // Region bookkeeping: circular pointers, occupancy, count of whole stored frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            occ     <= '0;
            frm_cnt <= '0;
        end else begin
            if (pop)     wr_ptr <= wr_ptr + 1'b1;
            if (rd_take) rd_ptr <= rd_ptr + 1'b1;
            occ     <= occ + OCC_W'(pop) - OCC_W'(rd_take);
            frm_cnt <= frm_cnt + OCC_W'(pop && ends_frame(q0)) - OCC_W'(frame_done);
        end
    end

    // R7: admission keeps the region within its size.
    a_r7_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(REGION_WORDS));

    // R3: the queue drains in time under the input gap rule.
    a_r3_queue_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && !pop && q_cnt == 2'd2));

    // R7: a drop counter moves by at most one per clock.
    a_r7_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (drops == $past(drops) || drops == $past(drops) + 1'b1));

    // R8: a saturated counter stays saturated.
    a_r8_drop_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        drops == CNT_TOP |=> drops == CNT_TOP);
endmodule

// File: rtl/tsb_reader.sv
// Read side: in slot 3 issues one word read when the output word buffer is
// empty and nothing is in flight, staying on one region until the frame's
// delimiter returns, otherwise picking the next region with a whole frame
// in rotating order. Tracks the two-cycle memory latency with a valid pipe
// and unpacks the returned word symbol by symbol onto the output port.
module tsb_reader
    import tsb_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           slot,
    input  logic [NSTREAM-1:0]   avail,
    input  logic [NSTREAM*PTR_W-1:0] rd_ptrs,
    input  logic [WORD_W-1:0]    sram_q,
    output logic                 rd_en,
    output logic [PTR_W+1:0]     rd_addr,
    output logic [NSTREAM-1:0]   rd_take,
    output logic [NSTREAM-1:0]   frame_done,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic [7:0]           out_data,
    output logic                 out_last,
    output logic [1:0]           out_region
);
    logic [1:0]        cur, last_srv, pick, sel, lane;
    logic              found, in_frame, v1, v2, busy, issue, xfer;
    logic [2:0]        left;
    logic [WORD_W-1:0] wbuf;

    // Rotating choice among regions holding a whole frame.
    always_comb begin
        pick  = last_srv;
        found = 1'b0;
        for (int k = 1; k <= NSTREAM; k++) begin
            int idx;
            idx = (int'(last_srv) + k) % NSTREAM;
            if (!found && avail[idx]) begin
                pick  = 2'(idx);
                found = 1'b1;
            end
        end
    end

    assign busy    = (left != 3'd0) || v1 || v2;
    assign sel     = in_frame ? cur : pick;
    assign issue   = (slot == 2'd3) && !busy && (in_frame || found);
    assign rd_en   = issue;
    assign rd_addr = {sel, rd_ptrs[int'(sel)*PTR_W +: PTR_W]};
    assign rd_take = issue ? (NSTREAM'(1) << sel) : '0;
    assign frame_done = (v2 && ends_frame(sram_q)) ? (NSTREAM'(1) << cur) : '0;

    assign out_valid  = (left != 3'd0);
    assign out_data   = wbuf[int'(lane)*SYM_W +: 8];
    assign out_last   = wbuf[int'(lane)*SYM_W + 8];
    assign out_region = cur;
    assign xfer       = out_valid && out_ready;

    // Read issue, region selection and the latency pipe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur      <= 2'd0;
            last_srv <= 2'(NSTREAM - 1);
            in_frame <= 1'b0;
            v1       <= 1'b0;
            v2       <= 1'b0;
        end else begin
            v1 <= issue;
            v2 <= v1;
            if (issue && !in_frame) begin
                cur      <= pick;
                last_srv <= pick;
                in_frame <= 1'b1;
            end
            if (v2 && ends_frame(sram_q)) in_frame <= 1'b0;
        end
    end

    // Output word buffer: load on return, step one symbol per accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbuf <= '0;
            lane <= 2'd0;
            left <= 3'd0;
        end else if (v2) begin
            wbuf <= sram_q;
            lane <= 2'd0;
            left <= valid_lanes(sram_q);
        end else if (xfer) begin
            lane <= lane + 2'd1;
            left <= left - 3'd1;
        end
    end

    // R9: a stalled symbol stays put.
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_last) && $stable(out_region));

    // R5: within a frame the region does not change.
    a_r5_frame_region: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && !out_last |=> $stable(out_region));

    // R6: a new frame is only started from a region that holds one.
    a_r6_pick_has_frame: assert property (@(posedge clk) disable iff (!rst_n)
        issue && !in_frame |-> avail[pick]);
endmodule

// File: rtl/tsb_ctrl.sv
// Top: three stream writers, one reader and the memory model, tied by a
// free-running four-slot counter. Slots 0..2 are write slots for streams
// 0..2, slot 3 is the read slot. Region s occupies addresses {s, ptr}.
module tsb_ctrl
    import tsb_pkg::*;
#(
    parameter int REGION_WORDS = 16,
    parameter int MAX_FRAME    = 16,
    parameter int CNT_W        = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             in_valid,
    input  logic [23:0]            in_data,
    input  logic [2:0]             in_last,
    input  logic                   out_ready,
    output logic                   out_valid,
    output logic [7:0]             out_data,
    output logic                   out_last,
    output logic [1:0]             out_region,
    output logic [3*CNT_W-1:0]     drop_cnt
);
    localparam int PTR_W  = $clog2(REGION_WORDS);
    localparam int ADDR_W = PTR_W + 2;

    logic [1:0]         slot;
    logic [NSTREAM-1:0] w_en, avail, rd_take, frame_done;
    logic [PTR_W-1:0]   w_ptr  [NSTREAM];
    logic [PTR_W-1:0]   r_ptr  [NSTREAM];
    logic [WORD_W-1:0]  w_word [NSTREAM];
    logic [NSTREAM*PTR_W-1:0] rd_ptrs;
    logic               rd_en, sram_we;
    logic [ADDR_W-1:0]  rd_addr, sram_addr;
    logic [WORD_W-1:0]  sram_wdata, sram_q;

    // Slot counter for the fixed access rotation.
    always_ff @(posedge clk) begin
        if (!rst_n) slot <= 2'd0;
        else        slot <= slot + 2'd1;
    end

    for (genvar g = 0; g < NSTREAM; g++) begin : g_wr
        tsb_writer #(
            .REGION_WORDS(REGION_WORDS),
            .MAX_FRAME   (MAX_FRAME),
            .CNT_W       (CNT_W),
            .MY_SLOT     (g)
        ) u_wr (
            .clk        (clk),
            .rst_n      (rst_n),
            .slot       (slot),
            .in_valid   (in_valid[g]),
            .in_data    (in_data[g*8 +: 8]),
            .in_last    (in_last[g]),
            .rd_take    (rd_take[g]),
            .frame_done (frame_done[g]),
            .wr_en      (w_en[g]),
            .wr_ptr     (w_ptr[g]),
            .wr_word    (w_word[g]),
            .rd_ptr     (r_ptr[g]),
            .frame_avail(avail[g]),
            .drops      (drop_cnt[g*CNT_W +: CNT_W])
        );
        assign rd_ptrs[g*PTR_W +: PTR_W] = r_ptr[g];

        // R3: each writer uses only its own slot.
        a_r3_write_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
            w_en[g] |-> slot == 2'(g));
    end

    tsb_reader #(.PTR_W(PTR_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot      (slot),
        .avail     (avail),
        .rd_ptrs   (rd_ptrs),
        .sram_q    (sram_q),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_take   (rd_take),
        .frame_done(frame_done),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .out_region(out_region)
    );

    // Memory port mux: the slot owner drives the single access.
    always_comb begin
        sram_we    = 1'b0;
        sram_addr  = rd_addr;
        sram_wdata = '0;
        for (int s = 0; s < NSTREAM; s++) begin
            if (w_en[s]) begin
                sram_we    = 1'b1;
                sram_addr  = {2'(s), w_ptr[s]};
                sram_wdata = w_word[s];
            end
        end
    end

    tsb_sram #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_mem (
        .clk  (clk),
        .we   (sram_we),
        .addr (sram_addr),
        .wdata(sram_wdata),
        .rdata(sram_q)
    );

    // R3: never more than one memory access per clock.
    a_r3_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({w_en, rd_en}));

    // R3: reads only in the last slot.
    a_r3_read_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> slot == 2'd3);
endmodule

// File: tb/tb_tsb_ctrl.sv
module tb_tsb_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 16;
    localparam int MF = 16;
    localparam int CW = 8;

    logic clk, rst_n, out_ready;
    logic out_valid, out_last;
    logic [7:0] out_data;
    logic [1:0] out_region;
    logic [3*CW-1:0] drop_cnt;
    logic       vin [3];
    logic [7:0] din [3];
    logic       lin [3];

    tsb_ctrl #(.REGION_WORDS(RW), .MAX_FRAME(MF), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid({vin[2], vin[1], vin[0]}),
        .in_data({din[2], din[1], din[0]}),
        .in_last({lin[2], lin[1], lin[0]}),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .out_region(out_region), .drop_cnt(drop_cnt)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0, miscompares = 0;
    bit done = 0;
    logic [8:0] exp_mem [3][2048];
    int exp_wr[3], exp_rd[3], fid[3];
    int mid = 0, cur_r = 0, prev_r = 0, have_prev = 0, rr_phase = 0, rr_frames = 0;
    int hold_p = 0;
    logic [11:0] h_val;

    function automatic logic [7:0] pat(int s, int f, int i);
        return 8'((s * 71 + f * 13 + i * 5 + 1) & 255);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_frame(int s, int len, bit keep);
        int f = fid[s];
        fid[s]++;
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            vin[s] = 1'b1;
            din[s] = pat(s, f, i);
            lin[s] = (i == len - 1);
            if (keep) begin
                exp_mem[s][exp_wr[s]] = {(i == len - 1), pat(s, f, i)};
                exp_wr[s]++;
            end
        end
        @(posedge clk); #1;
        vin[s] = 1'b0;
        lin[s] = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    // Output monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_p != 0) begin
                check(out_valid && {out_last, out_data, out_region} == h_val[10:0],
                      "R9 hold", int'({out_last, out_data, out_region}), int'(h_val[10:0]));
                hold_p = 0;
            end
            if (out_valid && !out_ready) begin
                hold_p = 1;
                h_val  = {1'b0, out_last, out_data, out_region};
            end
            if (out_valid && out_ready) begin
                int r;
                r = int'(out_region);
                if (r > 2) check(1'b0, "R2 region code", r, 0);
                else begin
                    if (exp_rd[r] >= exp_wr[r])
                        check(1'b0, "R2 unexpected symbol", exp_rd[r], exp_wr[r]);
                    else begin
                        check({out_last, out_data} == exp_mem[r][exp_rd[r]], "R2 R4 symbol",
                              int'({out_last, out_data}), int'(exp_mem[r][exp_rd[r]]));
                        exp_rd[r]++;
                    end
                    if (mid != 0) check(r == cur_r, "R5 frame atomic", r, cur_r);
                    else if (rr_phase != 0) begin
                        if (have_prev != 0)
                            check(r == (prev_r + 1) % 3, "R6 round robin", r, (prev_r + 1) % 3);
                        prev_r = r;
                        have_prev = 1;
                        rr_frames++;
                    end
                    mid   = out_last ? 0 : 1;
                    cur_r = r;
                end
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        for (int s = 0; s < 3; s++) begin
            vin[s] = 0; din[s] = 0; lin[s] = 0;
            exp_wr[s] = 0; exp_rd[s] = 0; fid[s] = 0;
        end
        rst_n = 1'b0;
        out_ready = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(drop_cnt == '0, "R1 drop counters", int'(drop_cnt), 0);

        // R4: every frame length on every stream, one at a time.
        for (int s = 0; s < 3; s++)
            for (int len = 1; len <= MF; len++) begin
                send_frame(s, len, 1'b1);
                repeat (70) @(posedge clk);
            end

        // R3: all streams at once, several lengths and back-to-back frames.
        for (int k = 0; k < 3; k++) begin
            int len;
            len = (k == 0) ? 5 : (k == 1) ? 12 : 16;
            fork
                send_frame(0, len, 1'b1);
                send_frame(1, len, 1'b1);
                send_frame(2, len, 1'b1);
            join
            repeat (150) @(posedge clk);
        end
        fork
            begin for (int j = 0; j < 3; j++) send_frame(0, 9, 1'b1); end
            begin for (int j = 0; j < 3; j++) send_frame(1, 9, 1'b1); end
            begin for (int j = 0; j < 3; j++) send_frame(2, 9, 1'b1); end
        join
        repeat (300) @(posedge clk);
        for (int s = 0; s < 3; s++)
            check(exp_rd[s] == exp_wr[s], "R3 concurrent streams delivered", exp_rd[s], exp_wr[s]);

        // R9: intermittent output stall.
        fork
            begin
                for (int i = 0; i < 200; i++) begin
                    @(posedge clk); #1;
                    out_ready = (i % 3) != 0;
                end
                out_ready = 1'b1;
            end
            begin
                send_frame(2, 11, 1'b1);
                send_frame(2, 11, 1'b1);
            end
        join
        repeat (100) @(posedge clk);

        // R6: load all regions while stalled, then release.
        @(posedge clk); #1 out_ready = 1'b0;
        rr_phase = 1; have_prev = 0; rr_frames = 0;
        fork
            begin for (int j = 0; j < 4; j++) send_frame(0, 8, 1'b1); end
            begin for (int j = 0; j < 4; j++) send_frame(1, 8, 1'b1); end
            begin for (int j = 0; j < 4; j++) send_frame(2, 8, 1'b1); end
        join
        repeat (20) @(posedge clk);
        #1 out_ready = 1'b1;
        repeat (300) @(posedge clk);
        rr_phase = 0;
        check(rr_frames == 12, "R6 frames in rotation", rr_frames, 12);
        check(drop_cnt == '0, "R7 no drops with room", int'(drop_cnt), 0);

        // R7: overfill region 1 while stalled; model occupancy in words.
        @(posedge clk); #1 out_ready = 1'b0;
        begin
            int occm, ndrop;
            occm = 0; ndrop = 0;
            for (int k = 0; k < 10; k++) begin
                bit keep;
                keep = (RW - occm) >= (MF + 3) / 4;
                if (keep) occm += 2; else ndrop++;
                send_frame(1, 8, keep);
                repeat (8) @(posedge clk);
            end
            @(negedge clk);
            check(int'(drop_cnt[CW +: CW]) == ndrop, "R7 drop count", int'(drop_cnt[CW +: CW]), ndrop);
            check(drop_cnt[0 +: CW] == '0 && drop_cnt[2*CW +: CW] == '0, "R7 other regions",
                  int'(drop_cnt[0 +: CW]) + int'(drop_cnt[2*CW +: CW]), 0);
            // R8: keep dropping one-symbol frames past the counter limit.
            for (int k = 0; k < 260; k++) send_frame(1, 1, 1'b0);
            @(negedge clk);
            check(int'(drop_cnt[CW +: CW]) == 255, "R8 saturation", int'(drop_cnt[CW +: CW]), 255);
        end
        @(posedge clk); #1 out_ready = 1'b1;
        repeat (400) @(posedge clk);
        for (int s = 0; s < 3; s++)
            check(exp_rd[s] == exp_wr[s], "R2 all accepted frames delivered", exp_rd[s], exp_wr[s]);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog (all requirements): actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule